// File: doc/BRIEF.md
# Multi-Channel Serial ADC Word Deserializer

This block turns the double-data-rate serial outputs of a multi-lane analog-to-digital converter into parallel sample words. On every bit-clock cycle each lane delivers two bits, one sampled on the rising edge and one on the falling edge, and one shared frame-clock sample arrives with them. The frame-clock sample marks where each word begins. Samples arrive least significant bit first. They can be 12 or 14 bits wide, so a word lasts 6 or 7 bit-clock cycles.

The block locks onto the word boundaries and reassembles every lane into a 14-bit word aligned to the most significant bit. It raises a single valid strobe that all lanes share. It also keeps a 6-bit tap setting for an external delay line, which is stepped by increment and decrement pulses. A sync pulse starts a fresh alignment search and latches the resolution to use.

The output stream has a valid strobe but no ready input. A converter cannot be stalled, so the consumer must accept every word in the cycle its strobe is high. Control pins are plain level or pulse inputs.

Top module: `sadc_deser`

## Requirements
- R1: In each bit-clock cycle of a word, the rising-edge bit of a lane is the less significant of the two bits captured that cycle, and the falling-edge bit is the next one up.
- R2: Words arrive LSB first. The first cycle of a word carries bits 0 and 1, and cycle k carries bits 2k and 2k+1.
- R3: With 14-bit resolution latched, `word_o` bits 13..0 of each lane equal sample bits 13..0. Lane c occupies `word_o[14c+13:14c]`.
- R4: With 12-bit resolution latched, sample bits 11..0 appear on lane bits 13..2, and lane bits 1..0 are zero.
- R5: A word boundary is a cycle whose frame sample is 1 while the previous cycle's frame sample was 0. A word lasts 7 cycles at 14-bit resolution and 6 cycles at 12-bit resolution.
- R6: After a sync, the first boundary seen starts the alignment. The block locks once the next two words also start exactly on boundaries, so the third word is the first one marked valid. `valid_o` is high for one cycle, in the cycle after the last bit-clock cycle of each locked word.
- R7: When locked or aligning, a boundary that appears at any word position other than the first, or a missing boundary where a word should start, drops alignment. No word is marked valid for that cycle, and the search restarts at the next boundary.
- R8: `tap_o` adds one on an increment pulse and subtracts one on a decrement pulse. It wraps from 63 to 0 and from 0 to 63. It holds when both pulses or neither pulse are present.
- R9: A sync pulse latches `res14_i` and restarts the search. No word completing in the sync cycle is marked valid.
- R10: If `res14_i` differs from the latched resolution and no sync is present, the block unlocks. It marks no word valid until the next sync.
- R11: After reset `valid_o`, `tap_o` and `word_o` are zero, and the block waits for a sync before it aligns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (one cycle per pair of serial bits) |
| rst_n | input | 1 | Active-low synchronous reset |
| res14_i | input | 1 | Resolution select: 1 = 14-bit, 0 = 12-bit; latched on sync |
| sync_i | input | 1 | Restart alignment pulse |
| inc_i | input | 1 | Delay-tap increment pulse |
| dec_i | input | 1 | Delay-tap decrement pulse |
| frame_i | input | 1 | Frame-clock sample, shared by all lanes |
| rise_i | input | NUM_CH | Rising-edge data bit per lane |
| fall_i | input | NUM_CH | Falling-edge data bit per lane |
| word_o | output | NUM_CH*14 | Parallel MSB-aligned words, lane 0 lowest |
| valid_o | output | 1 | One-cycle strobe qualifying `word_o` |
| tap_o | output | 6 | Delay-line tap setting |

## Verification
The assertions rely on three assumptions about the inputs. Sync, increment and decrement are known after reset. The frame sample stays low for at least one cycle before each word starts. Words last at least six cycles, so strobes are never back to back.

The stimulus meets these assumptions. It drives a frame pattern that is high for the first half of each word and low for the rest. Resolution changes only during idle gaps. Alignment faults are created on purpose, either by shortening or lengthening a single word or by pulsing sync on a word's last cycle. The bench then checks the exact word at which the strobe returns.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_LOCK  = 2'd3
  } align_st_e;
endpackage

// File: rtl/sadc_tap.sv
module sadc_tap #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [TAP_W-1:0] tap_o
);
  logic [TAP_W-1:0] tap_q;

  // modular arithmetic gives the wrap at both ends
  always_ff @(posedge clk) begin
    if (!rst_n) tap_q <= '0;
    else if (inc_i && !dec_i) tap_q <= tap_q + 1'b1;
    else if (dec_i && !inc_i) tap_q <= tap_q - 1'b1;
  end

  assign tap_o = tap_q;

  AST_TAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i) |=> (tap_q == TAP_W'($past(tap_q) + 1'b1))); // R8
  AST_TAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i) |=> (tap_q == TAP_W'($past(tap_q) - 1'b1))); // R8
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == dec_i) |=> $stable(tap_q)); // R8
endmodule

// File: rtl/sadc_framer.sv
module sadc_framer
  import sadc_pkg::*;
#(
  parameter int LONG_CYC  = 7,
  parameter int SHORT_CYC = 6,
  parameter int PH_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res14_i,
  input  logic            sync_i,
  input  logic            frame_i,
  output logic [PH_W-1:0] phase_o,
  output logic            cap_o,
  output logic            last_o,
  output logic            res_o,
  output logic            valid_o
);
  align_st_e       state_q;
  logic            frame_q;
  logic [PH_W-1:0] cnt_q;
  logic            seen_q;
  logic            res_q;
  logic            valid_q;

  logic [PH_W-1:0] wlast;
  logic            edge_w, counting, at_start, last_w, mism_w, res_chg, drop_w;

  assign wlast    = res_q ? PH_W'(LONG_CYC - 1) : PH_W'(SHORT_CYC - 1);
  assign edge_w   = frame_i & ~frame_q;
  assign counting = (state_q == ST_ALIGN) || (state_q == ST_LOCK);
  assign at_start = (cnt_q == '0);
  assign last_w   = counting && (cnt_q == wlast);
  assign mism_w   = counting && (edge_w != at_start);
  assign res_chg  = (res14_i != res_q);
  assign drop_w   = sync_i | res_chg | mism_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      res_q   <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      frame_q <= frame_i;
      valid_q <= (state_q == ST_LOCK) && last_w && !drop_w;
      if (sync_i) begin
        state_q <= ST_HUNT;
        res_q   <= res14_i;
        cnt_q   <= '0;
        seen_q  <= 1'b0;
      end else if (res_chg) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_HUNT: if (edge_w) begin
            state_q <= ST_ALIGN;
            cnt_q   <= PH_W'(1);
            seen_q  <= 1'b0;
          end
          default: begin
            if (mism_w) begin
              state_q <= ST_HUNT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= last_w ? '0 : cnt_q + 1'b1;
              if (at_start && state_q == ST_ALIGN) begin
                if (seen_q) state_q <= ST_LOCK;
                else        seen_q  <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign phase_o = counting ? cnt_q : '0;
  assign cap_o   = counting || ((state_q == ST_HUNT) && edge_w);
  assign last_o  = last_w;
  assign res_o   = res_q;
  assign valid_o = valid_q;

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_VALID_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(state_q) == ST_LOCK)); // R6
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> (cnt_q <= wlast)); // R5
  AST_SYNC_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !valid_q); // R9
  AST_RES_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && (res14_i != res_q)) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/sadc_lane.sv
module sadc_lane #(
  parameter int OUT_W    = 14,
  parameter int SHORT_W  = 12,
  parameter int LONG_CYC = 7,
  parameter int PH_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cap_i,
  input  logic             last_i,
  input  logic             res14_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int PAD_W = OUT_W - SHORT_W;

  logic [OUT_W-1:0] sh_q, full_w, word_q;

  // rising-edge bit is the lower of each pair; pair k lands at bits 2k, 2k+1
  always_comb begin
    full_w = sh_q;
    for (int k = 0; k < LONG_CYC; k++) begin
      if (phase_i == PH_W'(k)) begin
        full_w[2*k]   = rise_i;
        full_w[2*k+1] = fall_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      if (cap_i) sh_q <= full_w;
      if (last_i) word_q <= res14_i ? full_w : {full_w[SHORT_W-1:0], {PAD_W{1'b0}}};
    end
  end

  assign word_o = word_q;

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && !res14_i) |=> (word_q[PAD_W-1:0] == '0)); // R4
endmodule

// File: rtl/sadc_deser.sv
module sadc_deser #(
  parameter int NUM_CH  = 2,
  parameter int OUT_W   = 14,
  parameter int SHORT_W = 12,
  parameter int TAP_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    res14_i,
  input  logic                    sync_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  input  logic                    frame_i,
  input  logic [NUM_CH-1:0]       rise_i,
  input  logic [NUM_CH-1:0]       fall_i,
  output logic [NUM_CH*OUT_W-1:0] word_o,
  output logic                    valid_o,
  output logic [TAP_W-1:0]        tap_o
);
  localparam int LONG_CYC  = OUT_W / 2;
  localparam int SHORT_CYC = SHORT_W / 2;
  localparam int PH_W      = $clog2(LONG_CYC + 1);

  logic [PH_W-1:0] phase;
  logic            cap, last, res_q;

  sadc_framer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .PH_W(PH_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .res14_i(res14_i), .sync_i(sync_i), .frame_i(frame_i),
    .phase_o(phase), .cap_o(cap), .last_o(last), .res_o(res_q), .valid_o(valid_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    sadc_lane #(.OUT_W(OUT_W), .SHORT_W(SHORT_W), .LONG_CYC(LONG_CYC), .PH_W(PH_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .rise_i(rise_i[c]), .fall_i(fall_i[c]),
      .phase_i(phase), .cap_i(cap), .last_i(last), .res14_i(res_q),
      .word_o(word_o[c*OUT_W +: OUT_W])
    );
  end

  sadc_tap #(.TAP_W(TAP_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i), .tap_o(tap_o)
  );
endmodule

// File: tb/test_sadc_deser.sv
module test_sadc_deser;
  localparam int NCH = 2;
  localparam int OW  = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res14 = 1'b1, sync = 1'b0, inc = 1'b0, dec = 1'b0, frame = 1'b0;
  logic [NCH-1:0] rise = '0, fall = '0;
  logic [NCH*OW-1:0] word;
  logic valid;
  logic [5:0] tap;

  int checks = 0, fails = 0;
  logic [NCH*OW-1:0] exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  sadc_deser i_sadc_deser (
    .clk(clk), .rst_n(rst_n), .res14_i(res14), .sync_i(sync), .inc_i(inc), .dec_i(dec),
    .frame_i(frame), .rise_i(rise), .fall_i(fall), .word_o(word), .valid_o(valid), .tap_o(tap)
  );

  // every strobe must match the next expected word; none may appear unannounced
  always @(negedge clk) begin
    logic [NCH*OW-1:0] e;
    string r;
    if (rst_n && valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected valid: actual word=%h, expected no strobe", word);
      end else begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (word !== e) begin
          fails++;
          $display("FAIL %s word: actual %h expected %h", r, word, e);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      frame = 1'b0; rise = '0; fall = '0; sync = 1'b0; inc = 1'b0; dec = 1'b0;
    end
  endtask

  task automatic do_sync(input logic r);
    @(negedge clk);
    res14 = r; sync = 1'b1; frame = 1'b0; rise = '0; fall = '0;
    @(negedge clk);
    sync = 1'b0;
  endtask

  // drives one word for len cycles; frame high in the first half of a word
  task automatic send_word(input logic [13:0] v0, input logic [13:0] v1, input bit expv,
                           input string req, input int len, input bit sync_last);
    int w = res14 ? 7 : 6;
    logic [13:0] e0, e1;
    e0 = res14 ? v0 : {v0[11:0], 2'b00};
    e1 = res14 ? v1 : {v1[11:0], 2'b00};
    if (expv) begin
      exp_q.push_back({e1, e0});
      req_q.push_back(req);
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      frame = (k < w / 2);
      sync  = sync_last && (k == w - 1);
      if (k < w) begin
        rise[0] = v0[2*k]; fall[0] = v0[2*k+1];
        rise[1] = v1[2*k]; fall[1] = v1[2*k+1];
      end else begin
        rise = '0; fall = '0;
      end
    end
  endtask

  task automatic tap_op(input logic i, input logic d, input int expv, input string req);
    @(negedge clk);
    inc = i; dec = d;
    @(negedge clk);
    inc = 1'b0; dec = 1'b0;
    chk(req, 32'(tap), 32'(expv));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired: actual hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t;
    logic [13:0] v;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 valid", 32'(valid), 0);
    chk("R11 tap", 32'(tap), 0);
    chk("R11 word", 32'(word), 0);
    rst_n = 1'b1;
    idle(2);
    // R11 no alignment before a sync
    for (int i = 0; i < 4; i++) send_word(14'(i * 77), 14'(i * 91), 1'b0, "R11", 7, 1'b0);
    idle(2);

    // R8 tap stepping and wrap
    tap_op(1'b0, 1'b1, 63, "R8 wrap down");
    tap_op(1'b1, 1'b0, 0, "R8 wrap up");
    t = 0;
    for (int i = 0; i < 70; i++) begin
      t = (t + 1) % 64;
      tap_op(1'b1, 1'b0, t, "R8 inc");
    end
    tap_op(1'b1, 1'b1, t, "R8 both hold");
    tap_op(1'b0, 1'b0, t, "R8 none hold");
    t = (t + 63) % 64;
    tap_op(1'b0, 1'b1, t, "R8 dec");

    // R1 R2 R3 R5 R6 14-bit sweep, third word first valid
    do_sync(1'b1);
    for (int i = 0; i < 5462; i++) begin
      v = 14'(i * 3);
      send_word(v, 14'h3fff - v, i >= 2, "R1 R2 R3 R5 R6", 7, 1'b0);
    end
    // R7 short word: early boundary
    send_word(14'h1234, 14'h0abc, 1'b0, "R7", 6, 1'b0);
    send_word(14'h0001, 14'h0002, 1'b0, "R7", 7, 1'b0);
    send_word(14'h0003, 14'h0004, 1'b0, "R7", 7, 1'b0);
    send_word(14'h0005, 14'h0006, 1'b0, "R7", 7, 1'b0);
    send_word(14'h2aaa, 14'h1555, 1'b1, "R7 relock", 7, 1'b0);
    // R7 long word: missing boundary
    send_word(14'h3c3c, 14'h0f0f, 1'b1, "R7 long", 8, 1'b0);
    send_word(14'h0011, 14'h0022, 1'b0, "R7", 7, 1'b0);
    send_word(14'h0033, 14'h0044, 1'b0, "R7", 7, 1'b0);
    send_word(14'h3001, 14'h0003, 1'b1, "R7 relock", 7, 1'b0);
    // R9 sync on last cycle kills that word and restarts search
    send_word(14'h1111, 14'h2222, 1'b0, "R9", 7, 1'b1);
    send_word(14'h0100, 14'h0200, 1'b0, "R9", 7, 1'b0);
    send_word(14'h0300, 14'h0400, 1'b0, "R9", 7, 1'b0);
    send_word(14'h3ffe, 14'h0001, 1'b1, "R9 relock", 7, 1'b0);
    idle(3);

    // R10 resolution change without sync leaves the block unlocked
    @(negedge clk);
    res14 = 1'b0;
    for (int i = 0; i < 5; i++) send_word(14'(i * 5 + 1), 14'(i * 9 + 2), 1'b0, "R10", 6, 1'b0);
    idle(2);
    chk("R10 valid low", 32'(valid), 0);

    // R4 R5 12-bit exhaustive sweep
    do_sync(1'b0);
    for (int i = 0; i < 4096; i++)
      send_word(14'(i), 14'(4095 - i), i >= 2, "R4 R5", 6, 1'b0);
    idle(4);
    chk("R6 all expected words seen", 32'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule